// File: doc/BRIEF.md
# Block Memory Micro-op Sequencer

This block takes one decoded block load or block store and turns it into eight doubleword memory requests. The requests go out one after another on a valid/ready port. When the instruction is accepted, the block adds the base register value to either a second register value or a sign-extended 13-bit immediate. Each step then adds its own 8-byte offset to that sum. Each step also moves the register index one place further into an eight-register group. The first request carries a first flag and the eighth carries a last flag. The fault check is made once, against the combined base address, before any request is issued.

A faulting instruction issues no requests at all. Instead the block raises a one-cycle fault pulse with a code, and it is ready again at once. A clean instruction keeps the block busy until its eighth request has been accepted. Only then can the next instruction enter.

Top module: `blockMemSeq`

## Requirements
- R1: A clean instruction issues exactly eight requests. `reqFirst` is 1 only on the first of them and `reqLast` is 1 only on the eighth.
- R2: In register form (`instUseImm`=0), request n (n = 0..7) has address `instBase + instSecond + 8*n`, computed modulo 2^ADDR_W.
- R3: In immediate form (`instUseImm`=1), `instImm` is treated as a 13-bit two's-complement value and sign-extended before it is added, so request n has address `instBase + sext(instImm) + 8*n`.
- R4: Request n carries register index `instRegBase + n`, computed modulo 2^REG_W.
- R5: `reqIsStore` equals the accepted `instIsStore` on every request. Loads and stores produce the same addresses and register indices.
- R6: If the low 6 bits of the combined base address are not all zero, no request is issued. `faultValid` is 1 for exactly one cycle, starting the cycle after acceptance, with `faultCode` = 2 (alignment).
- R7: If the combined base address is aligned and `instPrivFault` is 1, the block reports `faultCode` = 1 (privilege) with no requests. When both faults are present, code 2 is reported.
- R8: While `reqValid` is 1 and `reqReady` is 0, the request fields stay unchanged on the next cycle.
- R9: `instReady` is 0 from the cycle after a clean acceptance until the eighth request has been accepted. It is 1 in the cycle after that, and a new instruction is accepted then.
- R10: After synchronous reset, `instReady`=1, `reqValid`=0 and `faultValid`=0. The step count is cleared, so the next clean instruction starts at step 0 with `reqFirst`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | Instruction offered |
| instReady | output | 1 | Sequencer idle, can accept |
| instIsStore | input | 1 | 1 = block store, 0 = block load |
| instUseImm | input | 1 | 1 = immediate form, 0 = register form |
| instBase | input | ADDR_W | Base register value |
| instSecond | input | ADDR_W | Second register value (register form) |
| instImm | input | 13 | Signed immediate (immediate form) |
| instRegBase | input | REG_W | First register index of the group |
| instPrivFault | input | 1 | Alternate-space privilege violation indication |
| reqValid | output | 1 | Memory request valid |
| reqReady | input | 1 | Memory request accepted |
| reqAddr | output | ADDR_W | Request effective address |
| reqReg | output | REG_W | Request register index |
| reqIsStore | output | 1 | Request direction |
| reqFirst | output | 1 | First request of the instruction |
| reqLast | output | 1 | Last request of the instruction |
| faultValid | output | 1 | One-cycle fault pulse |
| faultCode | output | 2 | 0 none, 1 privilege, 2 alignment |

## Verification
The case that is hardest to reach from the ports is a request held under backpressure in the middle of the sequence. There the step counter must stay put while `instValid` is still being offered. The stimulus holds `reqReady` low for several cycles before each acceptance and keeps re-checking the held fields during those cycles. Fault priority is driven with a misaligned base together with the privilege indication. Register-index wrap is driven with a group base near the top of the index range.

// File: rtl/bmsPkg.sv
package bmsPkg;

  typedef struct packed {
    logic capture;
    logic advance;
    logic clear;
  } bmsStrobe_t;

  typedef enum logic [1:0] {
    FAULT_NONE  = 2'd0,
    FAULT_PRIV  = 2'd1,
    FAULT_ALIGN = 2'd2
  } bmsFault_e;

  typedef enum logic [0:0] {
    SEQ_IDLE  = 1'b0,
    SEQ_ISSUE = 1'b1
  } bmsState_e;

endpackage

// File: rtl/bmsFaultPick.sv
module bmsFaultPick
  import bmsPkg::*;
#(
  parameter int ALIGN_BITS = 6
) (
  input  logic [ALIGN_BITS-1:0] sumLow,
  input  logic                  privFault,
  output bmsFault_e             code
);
  // Alignment has the higher priority.
  always_comb begin
    if (|sumLow)        code = FAULT_ALIGN;
    else if (privFault) code = FAULT_PRIV;
    else                code = FAULT_NONE;
  end
endmodule

// File: rtl/bmsDatapath.sv
module bmsDatapath
  import bmsPkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int REG_W      = 5,
  parameter int IMM_W      = 13,
  parameter int STEPS      = 8,
  parameter int STEP_BYTES = 8,
  parameter int ALIGN_BITS = 6,
  localparam int STEP_W    = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  bmsStrobe_t        strobe,
  input  logic              instIsStore,
  input  logic              instUseImm,
  input  logic [ADDR_W-1:0] instBase,
  input  logic [ADDR_W-1:0] instSecond,
  input  logic [IMM_W-1:0]  instImm,
  input  logic [REG_W-1:0]  instRegBase,
  input  logic              instPrivFault,
  output logic              faultHit,
  output logic [1:0]        faultCode,
  output logic              stepIsLast,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [REG_W-1:0]  reqReg,
  output logic              reqIsStore,
  output logic              reqFirst,
  output logic              reqLast
);
  logic [ADDR_W-1:0] immExt;
  logic [ADDR_W-1:0] inSum;
  logic [ADDR_W-1:0] baseSum;
  logic [REG_W-1:0]  regBase;
  logic              isStore;
  logic [STEP_W-1:0] step;
  bmsFault_e         faultNow;
  bmsFault_e         faultHeld;

  assign immExt = {{(ADDR_W-IMM_W){instImm[IMM_W-1]}}, instImm};
  assign inSum  = instBase + (instUseImm ? immExt : instSecond);

  bmsFaultPick #(.ALIGN_BITS(ALIGN_BITS)) i_faultPick (
    .sumLow   (inSum[ALIGN_BITS-1:0]),
    .privFault(instPrivFault),
    .code     (faultNow)
  );

  assign faultHit = (faultNow != FAULT_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      baseSum   <= '0;
      regBase   <= '0;
      isStore   <= 1'b0;
      faultHeld <= FAULT_NONE;
    end else if (strobe.capture) begin
      baseSum   <= inSum;
      regBase   <= instRegBase;
      isStore   <= instIsStore;
      faultHeld <= faultNow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.capture || strobe.clear) step <= '0;
    else if (strobe.advance)                   step <= step + 1'b1;
  end

  assign stepIsLast = (step == STEP_W'(STEPS-1));
  assign reqAddr    = baseSum + ADDR_W'(step) * ADDR_W'(STEP_BYTES);
  assign reqReg     = regBase + REG_W'(step);
  assign reqIsStore = isStore;
  assign reqFirst   = (step == '0);
  assign reqLast    = stepIsLast;
  assign faultCode  = faultHeld;
endmodule

// File: rtl/bmsCtrl.sv
module bmsCtrl
  import bmsPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       instValid,
  input  logic       reqReady,
  input  logic       faultHit,
  input  logic       stepIsLast,
  output logic       instReady,
  output logic       reqValid,
  output logic       faultValid,
  output bmsStrobe_t strobe
);
  bmsState_e state;
  bmsState_e stateNext;
  logic      faultNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    faultNext = 1'b0;
    unique case (state)
      SEQ_IDLE: begin
        if (instValid) begin
          strobe.capture = 1'b1;
          if (faultHit) faultNext = 1'b1;
          else          stateNext = SEQ_ISSUE;
        end
      end
      SEQ_ISSUE: begin
        if (reqReady) begin
          if (stepIsLast) begin
            strobe.clear = 1'b1;
            stateNext    = SEQ_IDLE;
          end else begin
            strobe.advance = 1'b1;
          end
        end
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SEQ_IDLE;
      faultValid <= 1'b0;
    end else begin
      state      <= stateNext;
      faultValid <= faultNext;
    end
  end

  assign instReady = (state == SEQ_IDLE);
  assign reqValid  = (state == SEQ_ISSUE);
endmodule

// File: rtl/blockMemSeq.sv
module blockMemSeq
  import bmsPkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int REG_W      = 5,
  parameter int STEPS      = 8,
  parameter int STEP_BYTES = 8,
  parameter int ALIGN_BITS = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  output logic              instReady,
  input  logic              instIsStore,
  input  logic              instUseImm,
  input  logic [ADDR_W-1:0] instBase,
  input  logic [ADDR_W-1:0] instSecond,
  input  logic [12:0]       instImm,
  input  logic [REG_W-1:0]  instRegBase,
  input  logic              instPrivFault,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [REG_W-1:0]  reqReg,
  output logic              reqIsStore,
  output logic              reqFirst,
  output logic              reqLast,
  output logic              faultValid,
  output logic [1:0]        faultCode
);
  bmsStrobe_t strobe;
  logic       faultHit;
  logic       stepIsLast;

  bmsCtrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .instValid (instValid),
    .reqReady  (reqReady),
    .faultHit  (faultHit),
    .stepIsLast(stepIsLast),
    .instReady (instReady),
    .reqValid  (reqValid),
    .faultValid(faultValid),
    .strobe    (strobe)
  );

  bmsDatapath #(
    .ADDR_W    (ADDR_W),
    .REG_W     (REG_W),
    .IMM_W     (13),
    .STEPS     (STEPS),
    .STEP_BYTES(STEP_BYTES),
    .ALIGN_BITS(ALIGN_BITS)
  ) i_datapath (
    .clk          (clk),
    .rst          (rst),
    .strobe       (strobe),
    .instIsStore  (instIsStore),
    .instUseImm   (instUseImm),
    .instBase     (instBase),
    .instSecond   (instSecond),
    .instImm      (instImm),
    .instRegBase  (instRegBase),
    .instPrivFault(instPrivFault),
    .faultHit     (faultHit),
    .faultCode    (faultCode),
    .stepIsLast   (stepIsLast),
    .reqAddr      (reqAddr),
    .reqReg       (reqReg),
    .reqIsStore   (reqIsStore),
    .reqFirst     (reqFirst),
    .reqLast      (reqLast)
  );
endmodule

// File: rtl/bmsChecker.sv
module bmsChecker #(
  parameter int ADDR_W     = 64,
  parameter int REG_W      = 5,
  parameter int STEP_BYTES = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              instReady,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [REG_W-1:0]  reqReg,
  input logic              reqIsStore,
  input logic              reqFirst,
  input logic              reqLast,
  input logic              faultValid,
  input logic [1:0]        faultCode
);
  assert_first_last_apart_R1: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> !(reqFirst && reqLast));

  assert_last_ends_burst_R1: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && reqLast) |=> !reqValid);

  assert_addr_stride_R2: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && !reqLast) |=>
      (reqAddr == $past(reqAddr) + ADDR_W'(STEP_BYTES)));

  assert_reg_step_R4: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && !reqLast) |=> (reqReg == $past(reqReg) + 1'b1));

  assert_dir_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady && !reqLast) |=> $stable(reqIsStore));

  assert_fault_no_req_R6: assert property (@(posedge clk) disable iff (rst)
    faultValid |-> (!reqValid && faultCode != 2'd0));

  assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    faultValid |=> !faultValid);

  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !reqReady) |=>
      (reqValid && $stable(reqAddr) && $stable(reqReg) && $stable(reqFirst)));

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (rst)
    reqValid |-> !instReady);
endmodule

bind blockMemSeq bmsChecker #(
  .ADDR_W    (ADDR_W),
  .REG_W     (REG_W),
  .STEP_BYTES(STEP_BYTES)
) i_bmsChecker (
  .clk       (clk),
  .rst       (rst),
  .instReady (instReady),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqAddr   (reqAddr),
  .reqReg    (reqReg),
  .reqIsStore(reqIsStore),
  .reqFirst  (reqFirst),
  .reqLast   (reqLast),
  .faultValid(faultValid),
  .faultCode (faultCode)
);

// File: tb/test_blockMemSeq.sv
`timescale 1ns/1ps
module test_blockMemSeq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instValid = 1'b0;
  logic        instReady;
  logic        instIsStore = 1'b0;
  logic        instUseImm = 1'b0;
  logic [63:0] instBase = '0;
  logic [63:0] instSecond = '0;
  logic [12:0] instImm = '0;
  logic [4:0]  instRegBase = '0;
  logic        instPrivFault = 1'b0;
  logic        reqValid;
  logic        reqReady = 1'b0;
  logic [63:0] reqAddr;
  logic [4:0]  reqReg;
  logic        reqIsStore;
  logic        reqFirst;
  logic        reqLast;
  logic        faultValid;
  logic [1:0]  faultCode;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  blockMemSeq i_blockMemSeq (
    .clk(clk), .rst(rst), .instValid(instValid), .instReady(instReady),
    .instIsStore(instIsStore), .instUseImm(instUseImm), .instBase(instBase),
    .instSecond(instSecond), .instImm(instImm), .instRegBase(instRegBase),
    .instPrivFault(instPrivFault), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqReg(reqReg), .reqIsStore(reqIsStore),
    .reqFirst(reqFirst), .reqLast(reqLast), .faultValid(faultValid),
    .faultCode(faultCode)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Offer an instruction at a negedge; return at the negedge after acceptance.
  task automatic sendInst(input bit isStore, input bit useImm, input logic [63:0] base,
                          input logic [63:0] second, input logic [12:0] imm,
                          input logic [4:0] regBase, input bit priv);
    @(negedge clk);
    while (!instReady) @(negedge clk);
    instIsStore = isStore; instUseImm = useImm; instBase = base;
    instSecond = second; instImm = imm; instRegBase = regBase;
    instPrivFault = priv; instValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instValid = 1'b0;
  endtask

  task automatic checkOp(input int n, input logic [63:0] expAddr, input logic [4:0] expReg,
                         input bit expStore, input string tag);
    check(reqValid == 1'b1, {tag, " R1 valid"}, 64'(reqValid), 64'd1);
    check(reqAddr == expAddr, {tag, " R2/R3 addr"}, reqAddr, expAddr);
    check(reqReg == expReg, {tag, " R4 reg"}, 64'(reqReg), 64'(expReg));
    check(reqIsStore == expStore, {tag, " R5 dir"}, 64'(reqIsStore), 64'(expStore));
    check(reqFirst == (n == 0), {tag, " R1 first"}, 64'(reqFirst), 64'(n == 0));
    check(reqLast == (n == 7), {tag, " R1 last"}, 64'(reqLast), 64'(n == 7));
    check(instReady == 1'b0, {tag, " R9 busy"}, 64'(instReady), 64'd0);
  endtask

  // Drain eight requests, stalling each one for 'stall' cycles.
  task automatic drainOps(input logic [63:0] expBase, input logic [4:0] expReg,
                          input bit expStore, input int stall, input string tag);
    for (int n = 0; n < 8; n++) begin
      logic [63:0] ea = expBase + 64'(n * 8);
      logic [4:0]  rg = expReg + 5'(n);
      for (int s = 0; s < stall; s++) begin
        reqReady = 1'b0;
        instValid = 1'b1; // offered while busy; must not be taken
        checkOp(n, ea, rg, expStore, {tag, " R8 stall"});
        @(posedge clk);
        @(negedge clk);
        instValid = 1'b0;
      end
      checkOp(n, ea, rg, expStore, tag);
      reqReady = 1'b1;
      @(posedge clk);
      @(negedge clk);
      reqReady = 1'b0;
    end
    check(reqValid == 1'b0, {tag, " R1 eight only"}, 64'(reqValid), 64'd0);
    check(instReady == 1'b1, {tag, " R9 ready after last"}, 64'(instReady), 64'd1);
  endtask

  task automatic faultCase(input logic [63:0] base, input bit priv,
                           input logic [1:0] expCode, input string tag);
    sendInst(1'b0, 1'b0, base, 64'h0, 13'h0, 5'd3, priv);
    check(faultValid == 1'b1, {tag, " pulse"}, 64'(faultValid), 64'd1);
    check(faultCode == expCode, {tag, " code"}, 64'(faultCode), 64'(expCode));
    check(reqValid == 1'b0, {tag, " no req"}, 64'(reqValid), 64'd0);
    @(negedge clk);
    check(faultValid == 1'b0, {tag, " one cycle"}, 64'(faultValid), 64'd0);
    check(reqValid == 1'b0, {tag, " still no req"}, 64'(reqValid), 64'd0);
    check(instReady == 1'b1, {tag, " idle"}, 64'(instReady), 64'd1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(instReady == 1'b1, "R10 instReady", 64'(instReady), 64'd1);
    check(reqValid == 1'b0, "R10 reqValid", 64'(reqValid), 64'd0);
    check(faultValid == 1'b0, "R10 faultValid", 64'(faultValid), 64'd0);
  endtask

  task automatic testRegLoad();
    sendInst(1'b0, 1'b0, 64'h0000_1000, 64'h0000_0240, 13'h0, 5'd8, 1'b0);
    drainOps(64'h0000_1240, 5'd8, 1'b0, 0, "R2 regload");
  endtask

  task automatic testRegStoreStall();
    sendInst(1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFC0, 64'h80, 13'h0, 5'd16, 1'b0);
    drainOps(64'h40, 5'd16, 1'b1, 2, "R5 store");
  endtask

  task automatic testImmNeg();
    sendInst(1'b0, 1'b1, 64'h2040, 64'hDEAD, 13'h1FC0, 5'd0, 1'b0);
    drainOps(64'h2000, 5'd0, 1'b0, 1, "R3 immneg");
  endtask

  task automatic testImmPosWrap();
    sendInst(1'b1, 1'b1, 64'h3000, 64'h0, 13'h0FC0, 5'd28, 1'b0);
    drainOps(64'h3FC0, 5'd28, 1'b1, 0, "R4 wrap");
  endtask

  task automatic testBackToBack();
    // R9: a second instruction is taken right after the first finishes.
    sendInst(1'b0, 1'b0, 64'h100, 64'h0, 13'h0, 5'd1, 1'b0);
    drainOps(64'h100, 5'd1, 1'b0, 0, "R9 first");
    instIsStore = 1'b1; instUseImm = 1'b0; instBase = 64'h200; instSecond = 64'h0;
    instRegBase = 5'd9; instPrivFault = 1'b0; instValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    instValid = 1'b0;
    drainOps(64'h200, 5'd9, 1'b1, 0, "R9 second");
  endtask

  task automatic testResetMid();
    sendInst(1'b0, 1'b0, 64'h400, 64'h0, 13'h0, 5'd2, 1'b0);
    reqReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqReady = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(reqValid == 1'b0, "R10 mid reset idle", 64'(reqValid), 64'd0);
    sendInst(1'b0, 1'b0, 64'h500, 64'h0, 13'h0, 5'd4, 1'b0);
    drainOps(64'h500, 5'd4, 1'b0, 0, "R10 restart");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    testReset();
    testRegLoad();
    testRegStoreStall();
    testImmNeg();
    testImmPosWrap();
    faultCase(64'h1008, 1'b0, 2'd2, "R6 align");
    faultCase(64'h1000, 1'b1, 2'd1, "R7 priv");
    faultCase(64'h1020, 1'b1, 2'd2, "R7 both");
    testBackToBack();
    testResetMid();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule